// File: doc/BRIEF.md
# DDR Command-Bus Timing Monitor

This block watches the command bus of a registered DDR SDRAM and raises an error for every command that breaks an inter-command timing rule. It drives nothing onto the bus. On each rising clock edge it decodes the chip select, the three command strobes, the bank address and address bit 10. It keeps a record for each of the four banks that says whether the bank is open or closed. It also holds a set of per-bank and global down-counters. Each counter says how many more cycles must pass before a given kind of command becomes legal.

The timing limits are clock-cycle counts, with two exceptions: the write-recovery time and the row-precharge time. Those two are given in picoseconds together with the clock period. The monitor rounds each of them up to whole clocks on its own, so the write-with-auto-precharge window uses two separately rounded terms. All limits are captured while reset is held.

The monitor also models the auto-precharge windows. A read with auto-precharge may be issued before the row's minimum active time has run out. In that case the internal precharge waits for the active time to finish. The lockout then lasts until that point plus the precharge time.

An offending command produces a one-cycle pulse on the clock edge after the one that sampled it. The pulse carries a 4-bit rule code and the bank number. A read or write to a closed bank is reported on a separate protocol-error output.

Top module: `ddr_cmd_timing_mon`

## Requirements
- R1: Commands are decoded on the rising edge from (cs_n, ras_n, cas_n, we_n): activate L,L,H,H; read L,H,L,H; write L,H,L,L; precharge L,L,H,L; refresh L,L,L,H with cke high; mode-register set L,L,L,L; burst stop L,H,H,L. While cs_n is high there is no command. Every report is registered and appears on the edge after the one that sampled the command. The report is viol_vld high for one cycle, with viol_code and viol_bank (the command's bank address unless stated otherwise).
- R2: A read or write to an open bank fewer than t_rcd cycles after that bank's activate gives code 3.
- R3: An activate fewer than ceil(t_rp_ps/t_ck_ps) cycles after a precharge closed that bank gives code 4.
- R4: A precharge fewer than t_ras cycles after the bank's activate gives code 5. A precharge with a10 high ignores the bank address and checks every open bank; viol_bank is then the lowest offending bank.
- R5: An activate fewer than t_rrd cycles after any activate gives code 6.
- R6: A read fewer than BL/2 + t_wtr cycles after a write gives code 7.
- R7: A read with a10 high at cycle n closes the bank. Until cycle n + max(BL/2, remaining active time) + tRP, an activate, read, write or single-bank precharge to that bank gives code 2.
- R8: A write with a10 high at cycle n locks its bank in the same way, until n + max(BL/2 + 1 + tWR, remaining active time) + tRP. Here tWR and tRP are each ceil(ps/t_ck_ps), rounded separately.
- R9: A mode-register set gives code 8 while any bank is open or any precharge or lockout window is running. Any command fewer than t_mrd cycles after a mode-register set gives code 1.
- R10: A read or write to a closed bank pulses proto_err with proto_bank one cycle later, whatever the timing codes report.
- R11: When several rules are broken at once, the lowest nonzero code is reported.
- R12: The configuration inputs are captured while rst_n is low. After reset all banks are closed, no window is running and all outputs are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Command-bus clock |
| rst_n | input | 1 | Synchronous active-low reset; configuration captured while low |
| cke | input | 1 | Clock enable as seen on the bus |
| cs_n | input | 1 | Chip select, active low |
| ras_n | input | 1 | Row strobe, active low |
| cas_n | input | 1 | Column strobe, active low |
| we_n | input | 1 | Write enable, active low |
| ba | input | 2 | Bank address |
| a10 | input | 1 | Auto-precharge / all-bank select bit |
| cfg_trcd | input | 8 | Activate-to-column limit, cycles |
| cfg_tras | input | 8 | Minimum row active time, cycles |
| cfg_trrd | input | 8 | Activate-to-activate limit, cycles |
| cfg_twtr | input | 8 | Write-to-read turnaround, cycles |
| cfg_tmrd | input | 8 | Mode-register-set delay, cycles |
| cfg_bl | input | 8 | Burst length (2, 4 or 8) |
| cfg_twr_ps | input | 16 | Write recovery time, ps |
| cfg_trp_ps | input | 16 | Row precharge time, ps |
| cfg_tck_ps | input | 16 | Clock period, ps |
| viol_vld | output | 1 | One-cycle timing-violation pulse |
| viol_code | output | 4 | Rule code of the violation, 0 when none |
| viol_bank | output | 2 | Bank the violation refers to |
| proto_err | output | 1 | One-cycle pulse: read or write to a closed bank |
| proto_bank | output | 2 | Bank of the protocol error |

## Verification
The embedded properties check, on every cycle, that the counters only ever count down by one unless reloaded, that an activate always leaves its bank open, and that a lockout never runs while the bank is open. They also check that every violation or protocol pulse follows a decoded command on the previous edge. What the properties cannot show are the exact window lengths. These are the tRAS-extended read lockout and the separately rounded write lockout. The other two are priority between simultaneous rules and the lowest-bank choice for an all-bank precharge. The bench's scripted command streams show these by placing commands one cycle inside and exactly at each limit.

// File: rtl/ddrmon_pkg.sv
package ddrmon_pkg;

  typedef enum logic [2:0] {
    CMD_NOP = 3'd0,
    CMD_ACT = 3'd1,
    CMD_RD  = 3'd2,
    CMD_WR  = 3'd3,
    CMD_PRE = 3'd4,
    CMD_REF = 3'd5,
    CMD_MRS = 3'd6,
    CMD_BST = 3'd7
  } cmd_e;

  // Rule codes, lowest value has the highest priority.
  localparam logic [3:0] RULE_NONE = 4'd0;
  localparam logic [3:0] RULE_MRD  = 4'd1;
  localparam logic [3:0] RULE_APL  = 4'd2;
  localparam logic [3:0] RULE_RCD  = 4'd3;
  localparam logic [3:0] RULE_RP   = 4'd4;
  localparam logic [3:0] RULE_RAS  = 4'd5;
  localparam logic [3:0] RULE_RRD  = 4'd6;
  localparam logic [3:0] RULE_WTR  = 4'd7;
  localparam logic [3:0] RULE_MRS  = 4'd8;

  // Round a picosecond figure up to whole clocks.
  function automatic logic [15:0] ceil_clocks(input logic [15:0] ps,
                                               input logic [15:0] tck);
    logic [16:0] sum;
    if (tck == 16'd0) return ps;
    sum = {1'b0, ps} + {1'b0, tck} - 17'd1;
    return 16'(sum / {1'b0, tck});
  endfunction

  // Counter load for "at least n cycles apart": value seen one cycle later.
  function automatic logic [15:0] gap_load(input logic [15:0] n);
    return (n == 16'd0) ? 16'd0 : n - 16'd1;
  endfunction

  function automatic logic [15:0] max16(input logic [15:0] a,
                                         input logic [15:0] b);
    return (a > b) ? a : b;
  endfunction

endpackage

// File: rtl/ddrmon_decode.sv
module ddrmon_decode
  import ddrmon_pkg::*;
(
  input  logic cke,
  input  logic cs_n,
  input  logic ras_n,
  input  logic cas_n,
  input  logic we_n,
  output cmd_e cmd
);
  always_comb begin
    cmd = CMD_NOP;
    if (!cs_n) begin
      unique case ({ras_n, cas_n, we_n})
        3'b011:  cmd = CMD_ACT;
        3'b101:  cmd = CMD_RD;
        3'b100:  cmd = CMD_WR;
        3'b010:  cmd = CMD_PRE;
        3'b001:  cmd = cke ? CMD_REF : CMD_NOP;
        3'b000:  cmd = CMD_MRS;
        3'b110:  cmd = CMD_BST;
        default: cmd = CMD_NOP;
      endcase
    end
  end
endmodule

// File: rtl/ddrmon_bank.sv
module ddrmon_bank
  import ddrmon_pkg::*;
#(
  parameter int CW = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  cmd_e          cmd,
  input  logic          sel,
  input  logic          a10,
  input  logic [CW-1:0] t_rcd,
  input  logic [CW-1:0] t_ras,
  input  logic [CW-1:0] t_rp,
  input  logic [CW-1:0] t_wr,
  input  logic [CW-1:0] bl_half,
  output logic          is_open,
  output logic          rcd_busy,
  output logic          ras_busy,
  output logic          rp_busy,
  output logic          lock_busy
);
  logic [CW-1:0] rcd_cnt, ras_cnt, rp_cnt, lock_cnt;

  // Named internal events for the properties.
  logic ev_act, ev_pre, ev_ap, ev_ap_wr;
  logic [15:0] ap_base, ap_len;

  assign ev_act   = (cmd == CMD_ACT) && sel;
  assign ev_pre   = (cmd == CMD_PRE) && (a10 || sel) && is_open;
  assign ev_ap    = (cmd == CMD_RD || cmd == CMD_WR) && sel && a10 && is_open;
  assign ev_ap_wr = ev_ap && (cmd == CMD_WR);

  // Internal precharge starts after the burst (plus recovery for writes),
  // but never before the minimum active time has run out.
  assign ap_base = ev_ap_wr ? 16'(bl_half) + 16'd1 + 16'(t_wr) : 16'(bl_half);
  assign ap_len  = max16(ap_base, 16'(ras_cnt)) + 16'(t_rp);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      is_open  <= 1'b0;
      rcd_cnt  <= '0;
      ras_cnt  <= '0;
      rp_cnt   <= '0;
      lock_cnt <= '0;
    end else begin
      if (ev_act)                is_open <= 1'b1;
      else if (ev_pre || ev_ap)  is_open <= 1'b0;

      if (ev_act)                rcd_cnt <= CW'(gap_load(16'(t_rcd)));
      else if (rcd_cnt != '0)    rcd_cnt <= rcd_cnt - 1'b1;

      if (ev_act)                ras_cnt <= CW'(gap_load(16'(t_ras)));
      else if (ras_cnt != '0)    ras_cnt <= ras_cnt - 1'b1;

      if (ev_pre)                rp_cnt <= CW'(gap_load(16'(t_rp)));
      else if (rp_cnt != '0)     rp_cnt <= rp_cnt - 1'b1;

      if (ev_act)                lock_cnt <= '0;
      else if (ev_ap)            lock_cnt <= CW'(gap_load(ap_len));
      else if (lock_cnt != '0)   lock_cnt <= lock_cnt - 1'b1;
    end
  end

  assign rcd_busy  = rcd_cnt  != '0;
  assign ras_busy  = ras_cnt  != '0;
  assign rp_busy   = rp_cnt   != '0;
  assign lock_busy = lock_cnt != '0;

  // R2
  act_opens_bank_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ev_act |=> is_open);

  // R7
  lock_closed_chk: assert property (@(posedge clk) disable iff (!rst_n)
    lock_busy |-> !is_open);

  // R8
  lock_countdown_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(lock_cnt) != '0 && !$past(ev_act) && !$past(ev_ap))
      |-> (lock_cnt == $past(lock_cnt) - 1'b1));

  // R3
  rp_countdown_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(rp_cnt) != '0 && !$past(ev_pre)) |-> (rp_cnt == $past(rp_cnt) - 1'b1));

endmodule

// File: rtl/ddr_cmd_timing_mon.sv
module ddr_cmd_timing_mon
  import ddrmon_pkg::*;
#(
  parameter int NBANK = 4,
  parameter int CW    = 8,
  parameter int PSW   = 16,
  localparam int BAW  = $clog2(NBANK)
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           cke,
  input  logic           cs_n,
  input  logic           ras_n,
  input  logic           cas_n,
  input  logic           we_n,
  input  logic [BAW-1:0] ba,
  input  logic           a10,
  input  logic [CW-1:0]  cfg_trcd,
  input  logic [CW-1:0]  cfg_tras,
  input  logic [CW-1:0]  cfg_trrd,
  input  logic [CW-1:0]  cfg_twtr,
  input  logic [CW-1:0]  cfg_tmrd,
  input  logic [CW-1:0]  cfg_bl,
  input  logic [PSW-1:0] cfg_twr_ps,
  input  logic [PSW-1:0] cfg_trp_ps,
  input  logic [PSW-1:0] cfg_tck_ps,
  output logic           viol_vld,
  output logic [3:0]     viol_code,
  output logic [BAW-1:0] viol_bank,
  output logic           proto_err,
  output logic [BAW-1:0] proto_bank
);
  cmd_e cmd;

  ddrmon_decode u_dec (
    .cke(cke), .cs_n(cs_n), .ras_n(ras_n), .cas_n(cas_n), .we_n(we_n), .cmd(cmd)
  );

  // Configuration captured during reset.
  logic [CW-1:0] trcd_q, tras_q, trrd_q, twtr_q, tmrd_q, blh_q, twr_q, trp_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      trcd_q <= cfg_trcd;
      tras_q <= cfg_tras;
      trrd_q <= cfg_trrd;
      twtr_q <= cfg_twtr;
      tmrd_q <= cfg_tmrd;
      blh_q  <= cfg_bl >> 1;
      twr_q  <= CW'(ceil_clocks(16'(cfg_twr_ps), 16'(cfg_tck_ps)));
      trp_q  <= CW'(ceil_clocks(16'(cfg_trp_ps), 16'(cfg_tck_ps)));
    end
  end

  logic [NBANK-1:0] b_open, b_rcd, b_ras, b_rp, b_lock;

  for (genvar gi = 0; gi < NBANK; gi++) begin : g_bank
    ddrmon_bank #(.CW(CW)) u_bank (
      .clk(clk), .rst_n(rst_n), .cmd(cmd), .sel(ba == BAW'(gi)), .a10(a10),
      .t_rcd(trcd_q), .t_ras(tras_q), .t_rp(trp_q), .t_wr(twr_q), .bl_half(blh_q),
      .is_open(b_open[gi]), .rcd_busy(b_rcd[gi]), .ras_busy(b_ras[gi]),
      .rp_busy(b_rp[gi]), .lock_busy(b_lock[gi])
    );
  end

  // Global spacing counters.
  logic [CW-1:0] rrd_cnt, wtr_cnt, mrd_cnt;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      rrd_cnt <= '0;
      wtr_cnt <= '0;
      mrd_cnt <= '0;
    end else begin
      if (cmd == CMD_ACT)       rrd_cnt <= CW'(gap_load(16'(trrd_q)));
      else if (rrd_cnt != '0)   rrd_cnt <= rrd_cnt - 1'b1;
      if (cmd == CMD_WR)        wtr_cnt <= CW'(gap_load(16'(blh_q) + 16'(twtr_q)));
      else if (wtr_cnt != '0)   wtr_cnt <= wtr_cnt - 1'b1;
      if (cmd == CMD_MRS)       mrd_cnt <= CW'(gap_load(16'(tmrd_q)));
      else if (mrd_cnt != '0)   mrd_cnt <= mrd_cnt - 1'b1;
    end
  end

  // Rule flags for the sampled command.
  logic is_col, pre_one, pre_all;
  logic f_mrd, f_apl, f_rcd, f_rp, f_ras, f_rrd, f_wtr, f_mrs, f_proto;
  logic [NBANK-1:0] ras_hits;
  logic [BAW-1:0]   ras_low;

  assign is_col  = (cmd == CMD_RD) || (cmd == CMD_WR);
  assign pre_one = (cmd == CMD_PRE) && !a10;
  assign pre_all = (cmd == CMD_PRE) && a10;

  assign ras_hits = pre_all ? (b_open & b_ras)
                  : (pre_one ? ((b_open & b_ras) & (NBANK'(1) << ba)) : '0);

  always_comb begin
    ras_low = '0;
    for (int i = NBANK - 1; i >= 0; i--)
      if (ras_hits[i]) ras_low = BAW'(i);
  end

  assign f_mrd   = (cmd != CMD_NOP) && (mrd_cnt != '0);
  assign f_apl   = (cmd == CMD_ACT || is_col || pre_one) && b_lock[ba];
  assign f_rcd   = is_col && b_open[ba] && b_rcd[ba];
  assign f_rp    = (cmd == CMD_ACT) && b_rp[ba];
  assign f_ras   = |ras_hits;
  assign f_rrd   = (cmd == CMD_ACT) && (rrd_cnt != '0);
  assign f_wtr   = (cmd == CMD_RD) && (wtr_cnt != '0);
  assign f_mrs   = (cmd == CMD_MRS) && (|b_open || |b_rp || |b_lock);
  assign f_proto = is_col && !b_open[ba];

  logic [3:0] code_d;
  always_comb begin
    if      (f_mrd) code_d = RULE_MRD;
    else if (f_apl) code_d = RULE_APL;
    else if (f_rcd) code_d = RULE_RCD;
    else if (f_rp)  code_d = RULE_RP;
    else if (f_ras) code_d = RULE_RAS;
    else if (f_rrd) code_d = RULE_RRD;
    else if (f_wtr) code_d = RULE_WTR;
    else if (f_mrs) code_d = RULE_MRS;
    else            code_d = RULE_NONE;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      viol_vld   <= 1'b0;
      viol_code  <= RULE_NONE;
      viol_bank  <= '0;
      proto_err  <= 1'b0;
      proto_bank <= '0;
    end else begin
      viol_vld   <= code_d != RULE_NONE;
      viol_code  <= code_d;
      viol_bank  <= (code_d == RULE_RAS) ? ras_low : ba;
      proto_err  <= f_proto;
      proto_bank <= ba;
    end
  end

  // R1
  viol_after_cmd_chk: assert property (@(posedge clk) disable iff (!rst_n)
    viol_vld |-> $past(cmd != CMD_NOP));

  // R10
  proto_after_col_chk: assert property (@(posedge clk) disable iff (!rst_n)
    proto_err |-> $past(is_col));

  // R9
  mrd_countdown_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(mrd_cnt) != '0 && $past(cmd) != CMD_MRS) |-> (mrd_cnt == $past(mrd_cnt) - 1'b1));

  // R11
  code_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    viol_vld |=> (!viol_vld || $past(cmd) != CMD_NOP));

endmodule

// File: tb/sim_ddr_cmd_timing_mon.sv
`timescale 1ns/1ps
module sim_ddr_cmd_timing_mon;
  localparam int OP_NOP = 0, OP_ACT = 1, OP_RD = 2, OP_WR = 3, OP_PRE = 4,
                 OP_REF = 5, OP_MRS = 6, OP_BST = 7, OP_DES = 8;

  logic clk = 1'b0, rst_n = 1'b0;
  logic cke = 1'b1, cs_n = 1'b1, ras_n = 1'b1, cas_n = 1'b1, we_n = 1'b1, a10 = 1'b0;
  logic [1:0] ba = '0;
  logic viol_vld, proto_err;
  logic [3:0] viol_code;
  logic [1:0] viol_bank, proto_bank;

  always #4 clk = ~clk;

  ddr_cmd_timing_mon u0 (
    .clk(clk), .rst_n(rst_n), .cke(cke), .cs_n(cs_n), .ras_n(ras_n), .cas_n(cas_n),
    .we_n(we_n), .ba(ba), .a10(a10),
    .cfg_trcd(8'd3), .cfg_tras(8'd6), .cfg_trrd(8'd2), .cfg_twtr(8'd2),
    .cfg_tmrd(8'd2), .cfg_bl(8'd4),
    .cfg_twr_ps(16'd15000), .cfg_trp_ps(16'd20000), .cfg_tck_ps(16'd7500),
    .viol_vld(viol_vld), .viol_code(viol_code), .viol_bank(viol_bank),
    .proto_err(proto_err), .proto_bank(proto_bank)
  );

  typedef struct {
    logic [3:0] code;
    logic [1:0] bank;
    logic       perr;
    logic [1:0] pbank;
    string      tag;
  } exp_t;

  exp_t q[$];
  int nvec = 0, nbad = 0;
  bit running = 1'b0, done = 1'b0;

  task automatic check(input bit ok, input string tag, input string act, input string exp);
    nvec++;
    if (!ok) begin
      nbad++;
      $display("FAIL %s: got %s expected %s", tag, act, exp);
    end
  endtask

  task automatic issue(input int op, input int bnk, input bit ap, input int code,
                       input int vbank, input bit perr, input string tag);
    exp_t e;
    @(negedge clk);
    cs_n = 1'b0; ba = 2'(bnk); a10 = ap;
    case (op)
      OP_ACT: {ras_n, cas_n, we_n} = 3'b011;
      OP_RD:  {ras_n, cas_n, we_n} = 3'b101;
      OP_WR:  {ras_n, cas_n, we_n} = 3'b100;
      OP_PRE: {ras_n, cas_n, we_n} = 3'b010;
      OP_REF: {ras_n, cas_n, we_n} = 3'b001;
      OP_MRS: {ras_n, cas_n, we_n} = 3'b000;
      OP_BST: {ras_n, cas_n, we_n} = 3'b110;
      OP_DES: begin cs_n = 1'b1; {ras_n, cas_n, we_n} = 3'b000; end
      default: begin cs_n = 1'b1; {ras_n, cas_n, we_n} = 3'b111; end
    endcase
    e.code = 4'(code); e.bank = 2'(vbank); e.perr = perr; e.pbank = 2'(bnk); e.tag = tag;
    q.push_back(e);
  endtask

  task automatic nops(input int n);
    for (int i = 0; i < n; i++) issue(OP_NOP, 0, 0, 0, 0, 0, "R1 idle");
  endtask

  // Monitor: pops one expectation per edge after its command was sampled.
  always @(posedge clk) begin
    if (running) begin
      #2;
      if (q.size() > 0) begin
        exp_t e;
        e = q.pop_front();
        check(viol_vld == (e.code != 0) && viol_code == e.code &&
              (e.code == 0 || viol_bank == e.bank), e.tag,
              $sformatf("vld=%0b code=%0d bank=%0d", viol_vld, viol_code, viol_bank),
              $sformatf("vld=%0b code=%0d bank=%0d", e.code != 0, e.code, e.bank));
        check(proto_err == e.perr && (!e.perr || proto_bank == e.pbank), e.tag,
              $sformatf("perr=%0b pbank=%0d", proto_err, proto_bank),
              $sformatf("perr=%0b pbank=%0d", e.perr, e.pbank));
      end
    end
  end

  initial begin
    repeat (4) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R12: quiet after reset
    check(!viol_vld && viol_code == 0 && !proto_err, "R12 reset",
          $sformatf("vld=%0b code=%0d perr=%0b", viol_vld, viol_code, proto_err), "all zero");
    running = 1'b1;
    issue(OP_ACT, 0, 0, 0, 0, 0, "R1 act b0");             // c0
    issue(OP_ACT, 1, 0, 6, 1, 0, "R5 rrd");                // c1
    issue(OP_RD,  0, 0, 3, 0, 0, "R2 rcd early");          // c2
    issue(OP_RD,  0, 0, 0, 0, 0, "R2 rcd at limit");       // c3
    issue(OP_PRE, 0, 0, 5, 0, 0, "R4 ras early");          // c4
    issue(OP_ACT, 0, 0, 4, 0, 0, "R3 rp early");           // c5
    issue(OP_WR,  1, 0, 0, 0, 0, "R1 write");              // c6
    issue(OP_RD,  1, 0, 7, 1, 0, "R6 wtr early");          // c7
    nops(2);                                               // c8-c9
    issue(OP_RD,  1, 0, 0, 0, 0, "R6 wtr at limit");       // c10
    issue(OP_RD,  2, 0, 0, 0, 1, "R10 closed bank");       // c11
    issue(OP_PRE, 3, 1, 0, 0, 0, "R4 pre-all ok");         // c12
    issue(OP_MRS, 0, 0, 8, 0, 0, "R9 mrs during rp");      // c13
    issue(OP_ACT, 1, 0, 1, 1, 0, "R11 mrd over rp");       // c14
    nops(2);                                               // c15-c16
    issue(OP_RD,  1, 1, 0, 0, 0, "R7 read ap");            // c17
    nops(4);                                               // c18-c21
    issue(OP_PRE, 1, 0, 2, 1, 0, "R7 ras-extended lock");  // c22
    issue(OP_ACT, 1, 0, 0, 0, 0, "R7 lock expired");       // c23
    nops(2);                                               // c24-c25
    issue(OP_WR,  1, 1, 0, 0, 0, "R8 write ap");           // c26
    nops(6);                                               // c27-c32
    issue(OP_RD,  1, 0, 2, 1, 1, "R8 lock plus closed");   // c33
    issue(OP_ACT, 1, 0, 0, 0, 0, "R8 lock expired");       // c34
    nops(1);                                               // c35
    issue(OP_ACT, 2, 0, 0, 0, 0, "R5 rrd at limit");       // c36
    nops(1);                                               // c37
    issue(OP_PRE, 0, 1, 5, 1, 0, "R4 pre-all lowest");     // c38
    nops(2);                                               // c39-c40
    issue(OP_MRS, 0, 0, 0, 0, 0, "R9 mrs clean");          // c41
    issue(OP_DES, 0, 0, 0, 0, 0, "R1 deselect ignored");   // c42
    issue(OP_ACT, 3, 0, 0, 0, 0, "R9 mrd at limit");       // c43
    issue(OP_MRS, 2, 0, 8, 2, 0, "R9 mrs bank open");      // c44
    issue(OP_BST, 0, 0, 1, 0, 0, "R1 burst stop decoded"); // c45
    nops(2);
    repeat (2) @(negedge clk);
    running = 1'b0;
    check(q.size() == 0, "R1 drain", $sformatf("%0d left", q.size()), "0 left");
    if (!done) begin
      done = 1'b1;
      $display("== %0d vectors applied, %0d miscompares ==", nvec, nbad);
      $finish;
    end
  end

  initial begin
    #100000;
    if (!done) begin
      done = 1'b1;
      nvec++; nbad++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("== %0d vectors applied, %0d miscompares ==", nvec, nbad);
      $finish;
    end
  end
endmodule